// File: doc/BRIEF.md
# Sliding Binary-Weighted Correlator

This block is the digital core of a programmable matched filter for direct-sequence spread-spectrum reception. Incoming chip-rate samples are never shifted. Each sample is written in place into one slot of a bank of stationary sample registers. A circulating one-hot pointer selects that slot. Alongside the bank sits a binary reference ring that holds the time-reversed spreading code and rotates in step with the pointer, so the code slides past the stored samples.

Every cycle the block multiplies each stored sample by a weight taken from its reference bit and adds the products. The weights are +1/0 in unipolar mode and +1/−1 in bipolar mode. The registered sum is the correlation output. When the reference lines up with the received chip pattern, the sum peaks. A positive peak decodes data bit 1 and a negative peak decodes data bit 0. A programmable magnitude threshold marks which sums count as peaks.

The block is used by loading the reference through the parallel load port, then strobing one sample per chip. The load can be repeated at any time, for example to step through code phases.

Top module: `sliding_correlator`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer returns to slot 0, all samples and reference bits clear, and `corr_sum`, `corr_valid`, `peak_valid` and `data_bit` read zero.
- R2: The pointer stays one-hot. On every edge where `smp_valid` is high it advances from slot k to slot k+1, wrapping from slot N−1 to slot 0. Otherwise it holds.
- R3: When `smp_valid` is high, `smp_data` is written only into the slot the pointer selects before it advances. Every other slot keeps its value, and no slot changes when `smp_valid` is low. A sample therefore stays in place for N strobes.
- R4: On each strobe without a load, the reference ring rotates in the same direction as the pointer: bit k moves to bit k+1 and bit N−1 moves to bit 0. It holds when neither a strobe nor a load occurs.
- R5: When `code_load` is high, bit k of `code_word` goes into reference bit k. This takes precedence over rotation in that cycle, while the sample write and the pointer advance of a coincident strobe still take place.
- R6: With `bipolar_mode` = 0, a reference bit of 1 weights its sample by +1 and a bit of 0 weights it by 0. With `bipolar_mode` = 1, a 0 bit weights by −1 instead. Weighting never alters the stored samples: after the code is changed and restored, the sum returns to its earlier value.
- R7: `corr_sum` is a registered signed value of width SAMPLE_W + ceil(log2 N) + 1. After every edge it equals the weighted sum of the sample bank and reference as updated at that edge. `corr_valid` is high exactly in the cycle after a cycle with `smp_valid` high.
- R8: `data_bit` is 1 exactly when `corr_sum` is greater than zero. `peak_valid` is 1 exactly when the magnitude of `corr_sum` is greater than the unsigned `peak_thresh`. A magnitude equal to the threshold does not count as a peak.
- R9: Feed the chips 1,1,1,0,1,0,0 in time order from reset, with the reference loaded as 0010111 (bit 6 first) rotated by 0 to 6 positions. With samples of A/0 and unipolar weights, exactly one rotation (the unrotated one) gives 4A and all others give 2A. With samples of +A/−A, the peak is 4A and all others give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe: write sample, advance pointer, rotate reference |
| smp_data | input | SAMPLE_W | Signed input sample |
| code_load | input | 1 | Parallel load of the reference ring |
| code_word | input | N_TAPS | Reference pattern, bit k to slot k |
| bipolar_mode | input | 1 | 0: weights +1/0, 1: weights +1/−1 |
| peak_thresh | input | SUM_W−1 | Unsigned magnitude threshold for a peak |
| corr_sum | output | SUM_W | Registered signed correlation value |
| corr_valid | output | 1 | Sum reflects a new sample |
| peak_valid | output | 1 | Magnitude of the sum exceeds the threshold |
| data_bit | output | 1 | Despread bit, 1 for a positive sum |

## Verification
Two functions can land on the same edge: a reference load and a sample strobe. In that case the strobe's rotation must give way to the loaded word, while the sample write and the pointer step still happen. The bench provokes this pairing on purpose in a directed step, and at random throughout a long pseudo-random sweep where loads, strobes, weight modes and thresholds vary together. Each resulting sum is judged against a bench-side arithmetic model that applies the load-over-rotation rule and then recomputes the weighted sum, the sign bit and the threshold compare from scratch.

// File: rtl/corr_pkg.sv
package corr_pkg;

  typedef enum logic {
    WM_UNIPOLAR = 1'b0,
    WM_BIPOLAR  = 1'b1
  } weight_mode_e;

  typedef enum logic [1:0] {
    TW_ZERO  = 2'b00,
    TW_PLUS  = 2'b01,
    TW_MINUS = 2'b11
  } tap_weight_e;

  function automatic tap_weight_e weight_for(input logic code_bit, input weight_mode_e mode);
    if (code_bit) return TW_PLUS;
    if (mode == WM_BIPOLAR) return TW_MINUS;
    return TW_ZERO;
  endfunction

endpackage

// File: rtl/corr_index_ring.sv
module corr_index_ring #(
  parameter int N_TAPS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [N_TAPS-1:0] idx_q,
  output logic [N_TAPS-1:0] idx_d
);

  localparam logic [N_TAPS-1:0] IDX_HOME = N_TAPS'(1);

  always_comb begin
    if (adv) idx_d = {idx_q[N_TAPS-2:0], idx_q[N_TAPS-1]};
    else     idx_d = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= IDX_HOME;
    else     idx_q <= idx_d;
  end

endmodule

// File: rtl/corr_code_ring.sv
module corr_code_ring #(
  parameter int N_TAPS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              load,
  input  logic [N_TAPS-1:0] load_word,
  output logic [N_TAPS-1:0] code_q,
  output logic [N_TAPS-1:0] code_d
);

  always_comb begin
    if (load)     code_d = load_word;
    else if (adv) code_d = {code_q[N_TAPS-2:0], code_q[N_TAPS-1]};
    else          code_d = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end

endmodule

// File: rtl/corr_sample_bank.sv
module corr_sample_bank #(
  parameter int N_TAPS   = 7,
  parameter int SAMPLE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [N_TAPS-1:0]            sel,
  input  logic signed [SAMPLE_W-1:0]   din,
  output logic [N_TAPS*SAMPLE_W-1:0]   samp_q,
  output logic [N_TAPS*SAMPLE_W-1:0]   samp_d
);

  for (genvar k = 0; k < N_TAPS; k++) begin : g_slot
    logic signed [SAMPLE_W-1:0] slot_q;
    logic signed [SAMPLE_W-1:0] slot_d;

    always_comb begin
      if (wr_en && sel[k]) slot_d = din;
      else                 slot_d = slot_q;
    end

    always_ff @(posedge clk) begin
      if (rst) slot_q <= '0;
      else     slot_q <= slot_d;
    end

    assign samp_q[k*SAMPLE_W +: SAMPLE_W] = slot_q;
    assign samp_d[k*SAMPLE_W +: SAMPLE_W] = slot_d;
  end

endmodule

// File: rtl/corr_tap_sum.sv
module corr_tap_sum #(
  parameter int N_TAPS   = 7,
  parameter int SAMPLE_W = 8,
  parameter int SUM_W    = 12
) (
  input  logic [N_TAPS*SAMPLE_W-1:0]  samples,
  input  logic [N_TAPS-1:0]           code,
  input  corr_pkg::weight_mode_e      mode,
  output logic signed [SUM_W-1:0]     sum
);

  localparam int EXT_W = SUM_W - SAMPLE_W;

  logic signed [SUM_W-1:0] term [N_TAPS];

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    logic [SAMPLE_W-1:0]     raw;
    logic signed [SUM_W-1:0] ext;

    assign raw = samples[k*SAMPLE_W +: SAMPLE_W];
    assign ext = {{EXT_W{raw[SAMPLE_W-1]}}, raw};

    always_comb begin
      unique case (corr_pkg::weight_for(code[k], mode))
        corr_pkg::TW_PLUS:  term[k] = ext;
        corr_pkg::TW_MINUS: term[k] = -ext;
        default:            term[k] = '0;
      endcase
    end
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < N_TAPS; k++) sum = sum + term[k];
  end

endmodule

// File: rtl/sliding_correlator.sv
module sliding_correlator #(
  parameter int  N_TAPS   = 7,
  parameter int  SAMPLE_W = 8,
  localparam int SUM_W    = SAMPLE_W + $clog2(N_TAPS) + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic                       code_load,
  input  logic [N_TAPS-1:0]          code_word,
  input  logic                       bipolar_mode,
  input  logic [SUM_W-2:0]           peak_thresh,
  output logic signed [SUM_W-1:0]    corr_sum,
  output logic                       corr_valid,
  output logic                       peak_valid,
  output logic                       data_bit
);

  logic [N_TAPS-1:0]          idx_q;
  logic [N_TAPS-1:0]          idx_d;
  logic [N_TAPS-1:0]          code_q;
  logic [N_TAPS-1:0]          code_d;
  logic [N_TAPS*SAMPLE_W-1:0] samp_q;
  logic [N_TAPS*SAMPLE_W-1:0] samp_d;
  logic signed [SUM_W-1:0]    sum_d;
  logic [SUM_W-1:0]           mag_full;
  logic [SUM_W-2:0]           mag_d;

  corr_index_ring #(.N_TAPS(N_TAPS)) u_index (
    .clk   (clk),
    .rst   (rst),
    .adv   (smp_valid),
    .idx_q (idx_q),
    .idx_d (idx_d)
  );

  corr_code_ring #(.N_TAPS(N_TAPS)) u_code (
    .clk       (clk),
    .rst       (rst),
    .adv       (smp_valid),
    .load      (code_load),
    .load_word (code_word),
    .code_q    (code_q),
    .code_d    (code_d)
  );

  corr_sample_bank #(.N_TAPS(N_TAPS), .SAMPLE_W(SAMPLE_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (smp_valid),
    .sel    (idx_q),
    .din    (smp_data),
    .samp_q (samp_q),
    .samp_d (samp_d)
  );

  corr_tap_sum #(.N_TAPS(N_TAPS), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_sum (
    .samples (samp_d),
    .code    (code_d),
    .mode    (corr_pkg::weight_mode_e'(bipolar_mode)),
    .sum     (sum_d)
  );

  always_comb begin
    mag_full = sum_d[SUM_W-1] ? -sum_d : sum_d;
    mag_d    = mag_full[SUM_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_sum   <= '0;
      corr_valid <= 1'b0;
      peak_valid <= 1'b0;
      data_bit   <= 1'b0;
    end else begin
      corr_sum   <= sum_d;
      corr_valid <= smp_valid;
      peak_valid <= (mag_d > peak_thresh);
      data_bit   <= !sum_d[SUM_W-1] && (sum_d != '0);
    end
  end

endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
  parameter int N_TAPS   = 7,
  parameter int SAMPLE_W = 8,
  parameter int SUM_W    = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       smp_valid,
  input logic [SAMPLE_W-1:0]        smp_data,
  input logic                       code_load,
  input logic [N_TAPS-1:0]          code_word,
  input logic [N_TAPS-1:0]          idx_q,
  input logic [N_TAPS-1:0]          code_q,
  input logic [N_TAPS*SAMPLE_W-1:0] samp_q,
  input logic signed [SUM_W-1:0]    corr_sum,
  input logic                       corr_valid,
  input logic                       peak_valid,
  input logic                       data_bit
);

  AST_INDEX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(idx_q) == 1); // R2
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (idx_q == {$past(idx_q[N_TAPS-2:0]), $past(idx_q[N_TAPS-1])})); // R2
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(idx_q)); // R2

  for (genvar k = 0; k < N_TAPS; k++) begin : g_slot_chk
    AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && !idx_q[k]) |=> $stable(samp_q[k*SAMPLE_W +: SAMPLE_W])); // R3
    AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && idx_q[k]) |=> (samp_q[k*SAMPLE_W +: SAMPLE_W] == $past(smp_data))); // R3
  end

  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(samp_q)); // R3
  AST_CODE_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !code_load) |=> (code_q == {$past(code_q[N_TAPS-2:0]), $past(code_q[N_TAPS-1])})); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !code_load) |=> $stable(code_q)); // R4
  AST_CODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    code_load |=> (code_q == $past(code_word))); // R5
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> corr_valid); // R7
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !corr_valid); // R7
  AST_DATA_SIGN: assert property (@(posedge clk) disable iff (rst)
    data_bit == (corr_sum > 0)); // R8
  AST_PEAK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    peak_valid |-> (corr_sum != 0)); // R8

endmodule

bind sliding_correlator corr_checker #(
  .N_TAPS   (N_TAPS),
  .SAMPLE_W (SAMPLE_W),
  .SUM_W    (SUM_W)
) u_corr_checker (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .code_load  (code_load),
  .code_word  (code_word),
  .idx_q      (idx_q),
  .code_q     (code_q),
  .samp_q     (samp_q),
  .corr_sum   (corr_sum),
  .corr_valid (corr_valid),
  .peak_valid (peak_valid),
  .data_bit   (data_bit)
);

// File: tb/test_sliding_correlator.sv
`timescale 1ns/1ps
module test_sliding_correlator;

  localparam int N  = 7;
  localparam int W  = 8;
  localparam int SW = W + $clog2(N) + 1;
  localparam int AMP = 20;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_valid = 1'b0;
  logic signed [W-1:0]  smp_data = '0;
  logic                 code_load = 1'b0;
  logic [N-1:0]         code_word = '0;
  logic                 bipolar_mode = 1'b0;
  logic [SW-2:0]        peak_thresh = '0;
  logic signed [SW-1:0] corr_sum;
  logic                 corr_valid;
  logic                 peak_valid;
  logic                 data_bit;

  int n_cmp = 0;
  int n_bad = 0;
  int ms [N];
  logic [N-1:0] mcode;
  int midx;
  int act_sum;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sliding_correlator i_sliding_correlator (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .code_load    (code_load),
    .code_word    (code_word),
    .bipolar_mode (bipolar_mode),
    .peak_thresh  (peak_thresh),
    .corr_sum     (corr_sum),
    .corr_valid   (corr_valid),
    .peak_valid   (peak_valid),
    .data_bit     (data_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rotl(input logic [N-1:0] x, input int n);
    logic [N-1:0] r = x;
    for (int i = 0; i < n; i++) r = {r[N-2:0], r[N-1]};
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    smp_valid = 1'b0;
    code_load = 1'b0;
    repeat (2) @(negedge clk);
    chk(corr_sum == 0, "R1 sum after reset", int'(corr_sum), 0);
    chk({corr_valid, peak_valid, data_bit} == 3'b000, "R1 flags after reset",
        int'({corr_valid, peak_valid, data_bit}), 0);
    for (int k = 0; k < N; k++) ms[k] = 0;
    mcode = '0;
    midx = 0;
    rst = 1'b0;
  endtask

  task automatic cycle(input bit v, input int d, input bit ld, input logic [N-1:0] cw,
                       input string tag);
    int exp;
    int mag;
    smp_valid = v;
    smp_data  = W'(d);
    code_load = ld;
    code_word = cw;
    @(negedge clk);
    if (v) ms[midx] = d;
    if (ld)     mcode = cw;
    else if (v) mcode = {mcode[N-2:0], mcode[N-1]};
    if (v) midx = (midx + 1) % N;
    exp = 0;
    for (int k = 0; k < N; k++) begin
      if (mcode[k])          exp += ms[k];
      else if (bipolar_mode) exp -= ms[k];
    end
    act_sum = int'(corr_sum);
    mag = (exp < 0) ? -exp : exp;
    chk(act_sum == exp, {tag, " correlation sum"}, act_sum, exp);
    chk(corr_valid == v, "R7 valid latency", int'(corr_valid), int'(v));
    chk(peak_valid == (mag > int'(peak_thresh)), "R8 peak threshold", int'(peak_valid),
        int'(mag > int'(peak_thresh)));
    chk(data_bit == (exp > 0), "R8 data bit sign", int'(data_bit), int'(exp > 0));
    smp_valid = 1'b0;
    code_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [N-1:0] chips = 7'b1110100;
    int npk;
    int ref_sum;

    @(negedge clk);
    do_reset();
    cycle(0, 0, 0, '0, "R1");

    // R2 R4: single reference bit follows the pointer around the ring
    cycle(0, 0, 1, 7'b0000001, "R5");
    for (int j = 0; j < 2 * N; j++) cycle(1, 10 + j, 0, '0, "R2 R4");

    // R3: idle cycles with changing data leave the bank untouched
    cycle(0, 0, 1, 7'b1111111, "R5");
    for (int j = 0; j < 5; j++) cycle(0, -50 + 17 * j, 0, '0, "R3");

    // R5: load coinciding with a strobe
    cycle(1, 33, 1, 7'b0101010, "R5");
    cycle(1, -7, 1, 7'b1100011, "R5");

    // R6: bipolar weights at full scale, both signs
    do_reset();
    bipolar_mode = 1'b1;
    cycle(0, 0, 1, 7'b0000000, "R6");
    for (int j = 0; j < N; j++) cycle(1, -128, 0, '0, "R6");
    cycle(0, 0, 1, 7'b1111111, "R6");
    cycle(0, 0, 1, 7'b0110010, "R6");
    ref_sum = act_sum;
    cycle(0, 0, 1, 7'b1010101, "R6");
    cycle(0, 0, 1, 7'b0110010, "R6");
    chk(act_sum == ref_sum, "R6 samples unchanged by weighting", act_sum, ref_sum);
    bipolar_mode = 1'b0;

    // R9: pn code, unipolar signal, threshold just below the peak
    npk = 0;
    for (int o = 0; o < N; o++) begin
      do_reset();
      peak_thresh = SW'(4 * AMP - 1);
      cycle(0, 0, 1, rotl(7'b0010111, o), "R5");
      for (int j = 0; j < N; j++) cycle(1, chips[N-1-j] ? AMP : 0, 0, '0, "R9");
      chk(act_sum == 4 * AMP || act_sum == 2 * AMP, "R9 unipolar level", act_sum, 2 * AMP);
      if (act_sum == 4 * AMP) npk++;
      if (o == 0) begin
        chk(act_sum == 4 * AMP, "R9 aligned peak", act_sum, 4 * AMP);
        chk(peak_valid == 1'b1, "R8 peak flagged", int'(peak_valid), 1);
        peak_thresh = SW'(4 * AMP);
        cycle(0, 0, 0, '0, "R8");
        chk(peak_valid == 1'b0, "R8 magnitude equal to threshold", int'(peak_valid), 0);
      end
    end
    chk(npk == 1, "R9 unipolar peak count", npk, 1);

    // R9: pn code, bipolar signal
    npk = 0;
    for (int o = 0; o < N; o++) begin
      do_reset();
      cycle(0, 0, 1, rotl(7'b0010111, o), "R5");
      for (int j = 0; j < N; j++) cycle(1, chips[N-1-j] ? AMP : -AMP, 0, '0, "R9");
      chk(act_sum == 4 * AMP || act_sum == 0, "R9 bipolar level", act_sum, 0);
      if (act_sum == 4 * AMP) npk++;
    end
    chk(npk == 1, "R9 bipolar peak count", npk, 1);

    // R7: pseudo-random sweep over strobes, loads, modes, thresholds and data
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 500 == 0)  bipolar_mode = ~bipolar_mode;
      if (i % 64 == 0)   peak_thresh = SW'(lfsr[9:0]);
      d = int'($signed(lfsr[7:0]));
      if (i % 11 == 0) d = -128;
      if (i % 13 == 0) d = 127;
      cycle(lfsr[0] | lfsr[1], d, lfsr[15:13] == 3'b000, lfsr[12:6], "R7");
    end

    finished = 1'b1;
    finish_run();
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule